// File: doc/BRIEF.md
# Extended-Precision Partial Remainder Unit

This block takes two 80-bit extended-precision operands and computes the remainder of the first one (the dividend) over the second (the modulus). The remainder equals dividend − Q × modulus. A mode input picks how the integer Q is chosen: it can be truncated toward zero, or it can be rounded to the nearest integer, with ties going to the even value. The second choice keeps the magnitude of the result at or below half the modulus. The operands use the 80-bit layout: sign in bit 79, a biased exponent of 15 bits in bits 78:64 (bias 16383), and a 64-bit significand in bits 63:0 with an explicit integer bit.

A one-cycle `start` pulse latches both operands, the two empty tags and the mode. The quotient comes out one bit per clock from a restoring shift-and-subtract loop. A single `done` pulse marks the cycle in which the result registers take their new values. One operation lowers the dividend exponent by at most 63. When the exponents are further apart, the block returns a partial remainder and sets an incomplete flag, and software can run the operation again. On a complete reduction, the three low bits of Q are placed in condition-code positions that are not in their natural order.

Top module: `fprem_unit`

## Requirements
- R1: When `remMode`=0, the result is dividend − Q·modulus with Q truncated toward zero. A non-zero result takes the dividend's sign.
- R2: When `remMode`=1, Q is the nearest integer, and a tie goes to the even Q. The result magnitude is at most half the modulus, and its sign may be opposite to the dividend's (11 rem 7 gives −3, 10 rem 7 gives +3).
- R3: On a complete reduction, condCode[0]=Q bit 2, condCode[1]=Q bit 0, condCode[3]=Q bit 1 and condCode[2]=0.
- R4: If the biased dividend exponent exceeds the modulus exponent by more than 63, the result is the dividend reduced modulo (modulus·2^(diff−63)), with condCode = 4'b0100. The quotient bits stay at 0 in this case.
- R5: If either operand is tagged empty, either is a NaN (exponent 7FFFh, significand bits 62:0 non-zero), the dividend is infinite, or the modulus is zero, then `excInvalid`=1. The result is then 80'hFFFF_C000_0000_0000_0000 and condCode = 0.
- R6: `excStackFault`=1 exactly when an operand is tagged empty, and `excInvalid` is 1 along with it.
- R7: `excDenormal`=1 when a non-empty operand has exponent 0 and a non-zero significand, or when the result is denormal.
- R8: If the normalised result exponent would fall below 1, the result is returned as a denormal (exponent 0, significand shifted right) and both `excUnderflow` and `excDenormal` are 1.
- R9: A zero remainder is returned as a signed zero with the dividend's sign. A non-zero normal result has bit 63 set. A zero dividend, an infinite modulus, or a dividend too small to reduce is returned unchanged with condCode = 0.
- R10: `done` is a one-cycle pulse. It comes no more than 69 cycles after the accepted `start`. All result outputs hold their values between `done` pulses and are all zero after reset.
- R11: A `start` that arrives while an operation is in progress is ignored. The operands are latched at the accepted `start`, so later changes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request; accepted only when idle |
| remMode | input | 1 | 0 = truncating quotient, 1 = nearest-even quotient |
| dividendIn | input | 80 | Dividend operand |
| modulusIn | input | 80 | Modulus operand |
| dividendEmpty | input | 1 | Dividend register tagged empty |
| modulusEmpty | input | 1 | Modulus register tagged empty |
| done | output | 1 | Result valid pulse |
| remainderOut | output | 80 | Remainder or indefinite value |
| condCode | output | 4 | {C3=Q1, C2=incomplete, C1=Q0, C0=Q2} |
| excInvalid | output | 1 | Invalid operation |
| excStackFault | output | 1 | Operand tagged empty |
| excDenormal | output | 1 | Denormal operand or result |
| excUnderflow | output | 1 | Result below normal range |

## Verification
Two situations are hard to reach from the ports. The first is a rounding tie in nearest mode, where the remainder is exactly half the modulus. The second is the one-exponent-below case, where the dividend lies between half the modulus and the modulus. The stimulus uses small integers and halves (10.5 rem 7, 3.5 rem 7, 3.75 rem 7) so that both tie parities and the guard-bit path get hit exactly. For underflow, both exponents are placed at the bottom of the normal range. For the 63-step limit, the operands are 2^64 and 2^100 over 3, which separates a complete long run from a partial one with a known residue. That same long run is the window in which a second `start` and changed operands are applied.

// File: rtl/fprem_pkg.sv
`timescale 1ns/1ps
package fprem_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_ITER  = 3'd2,
    ST_ROUND = 3'd3,
    ST_NORM  = 3'd4
  } remState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic setup;
    logic step;
    logic round;
    logic finish;
  } dpCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic special;
    logic noIter;
    logic lastStep;
  } dpStat_t;

endpackage

// File: rtl/fprem_ctrl.sv
`timescale 1ns/1ps
module fprem_ctrl
  import fprem_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  dpStat_t stat,
  output dpCtl_t  ctl,
  output logic    done
);

  remState_e state, nextState;

  always_comb begin
    ctl       = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (start) begin
          ctl.load  = 1'b1;
          nextState = ST_SETUP;
        end
      end
      ST_SETUP: begin
        ctl.setup = 1'b1;
        if (stat.special)     nextState = ST_IDLE;
        else if (stat.noIter) nextState = ST_ROUND;
        else                  nextState = ST_ITER;
      end
      ST_ITER: begin
        ctl.step = 1'b1;
        if (stat.lastStep) nextState = ST_ROUND;
      end
      ST_ROUND: begin
        ctl.round = 1'b1;
        nextState = ST_NORM;
      end
      ST_NORM: begin
        ctl.finish = 1'b1;
        nextState  = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nextState;
      done  <= (ctl.setup && stat.special) || ctl.finish;
    end
  end

endmodule

// File: rtl/fprem_dp.sv
`timescale 1ns/1ps
module fprem_dp
  import fprem_pkg::*;
#(
  parameter int SIG_W   = 64,
  parameter int EXP_W   = 15,
  parameter int MAX_RED = 63
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dpCtl_t                   ctl,
  output dpStat_t                  stat,
  input  logic                     remMode,
  input  logic [EXP_W+SIG_W:0]     dividendIn,
  input  logic [EXP_W+SIG_W:0]     modulusIn,
  input  logic                     dividendEmpty,
  input  logic                     modulusEmpty,
  output logic [EXP_W+SIG_W:0]     remainderOut,
  output logic [3:0]               condCode,
  output logic [3:0]               excFlags
);

  localparam int FP_W  = 1 + EXP_W + SIG_W;
  localparam int REM_W = SIG_W + 2;
  localparam int CNT_W = $clog2(MAX_RED + 2);
  localparam int LZ_W  = $clog2(REM_W + 1);
  localparam int XW    = EXP_W + 3;
  localparam logic [EXP_W-1:0] EXP_MAX = {EXP_W{1'b1}};
  localparam logic signed [XW-1:0] ONE_S   = XW'(1);
  localparam logic signed [XW-1:0] MINUS1  = -XW'(1);
  localparam logic signed [XW-1:0] MAXR_S  = XW'(MAX_RED);
  localparam logic signed [XW-1:0] SIGW_S  = XW'(SIG_W);
  localparam logic [FP_W-1:0] INDEF = {1'b1, EXP_MAX, 2'b11, {(SIG_W-2){1'b0}}};

  // latched operands
  logic [FP_W-1:0] aReg, bReg;
  logic            modeReg, emptyA, emptyB;

  // iteration state
  logic [REM_W-1:0]        remR, divD;
  logic [2:0]              qBits;
  logic [CNT_W-1:0]        cnt;
  logic signed [XW-1:0]    baseExp;
  logic                    resSign, partial, denIn;

  // operand fields and classes
  logic             sA;
  logic [EXP_W-1:0] eA, eB;
  logic [SIG_W-1:0] mA, mB;
  logic aZero, aDen, aInf, aNaN, bZero, bDen, bInf, bNaN;
  logic signed [XW-1:0] eAx, eBx, diff;
  logic invalid, passA, anyEmpty;

  always_comb begin
    sA = aReg[FP_W-1];
    eA = aReg[FP_W-2:SIG_W];
    eB = bReg[FP_W-2:SIG_W];
    mA = aReg[SIG_W-1:0];
    mB = bReg[SIG_W-1:0];
    aZero = (eA == '0) && (mA == '0);
    aDen  = (eA == '0) && (mA != '0);
    aInf  = (eA == EXP_MAX) && (mA[SIG_W-2:0] == '0);
    aNaN  = (eA == EXP_MAX) && (mA[SIG_W-2:0] != '0);
    bZero = (eB == '0) && (mB == '0);
    bDen  = (eB == '0) && (mB != '0);
    bInf  = (eB == EXP_MAX) && (mB[SIG_W-2:0] == '0);
    bNaN  = (eB == EXP_MAX) && (mB[SIG_W-2:0] != '0);
    eAx = XW'(eA);
    if (eA == '0) eAx = ONE_S;
    eBx = XW'(eB);
    if (eB == '0) eBx = ONE_S;
    diff     = eAx - eBx;
    anyEmpty = emptyA || emptyB;
    invalid  = anyEmpty || aNaN || bNaN || aInf || bZero;
    passA    = !invalid && (aZero || bInf || (diff < MINUS1) ||
                            ((diff == MINUS1) && !modeReg));
    stat.special  = invalid || passA;
    stat.noIter   = (diff == MINUS1);
    stat.lastStep = (cnt == CNT_W'(1));
  end

  // one restoring step
  logic             geStep;
  logic [REM_W-1:0] subStep;
  always_comb begin
    geStep  = (remR >= divD);
    subStep = geStep ? (remR - divD) : remR;
  end

  // nearest-even decision
  logic [REM_W-1:0] halfMod;
  logic             roundUp;
  always_comb begin
    halfMod = {2'b00, mB};
    roundUp = modeReg && !partial &&
              ((remR > halfMod) || ((remR == halfMod) && qBits[0]));
  end

  // normalisation and underflow
  function automatic logic [LZ_W-1:0] leadZeros(input logic [REM_W-1:0] v);
    logic [LZ_W-1:0] n;
    n = LZ_W'(REM_W);
    for (int i = 0; i < REM_W; i++)
      if (v[i]) n = LZ_W'(REM_W - 1 - i);
    return n;
  endfunction

  logic [LZ_W-1:0]      lz;
  logic signed [XW-1:0] lzS, expN, shS;
  logic [REM_W-1:0]     normV;
  logic [SIG_W-1:0]     sigN, sigD;
  logic [FP_W-1:0]      finRes;
  logic                 finUfl, finDen;

  always_comb begin
    lz    = leadZeros(remR);
    lzS   = XW'(lz);
    normV = remR << lz;
    sigN  = normV[REM_W-1:2];
    expN  = baseExp - lzS + ONE_S;
    shS   = ONE_S - expN;
    sigD  = '0;
    finUfl = 1'b0;
    finDen = denIn;
    if (remR == '0) begin
      finRes = {resSign, {(FP_W-1){1'b0}}};
    end else if (expN >= ONE_S) begin
      finRes = {resSign, expN[EXP_W-1:0], sigN};
    end else begin
      if (shS < SIGW_S) sigD = sigN >> shS;
      finRes = {resSign, {EXP_W{1'b0}}, sigD};
      finUfl = 1'b1;
      finDen = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aReg <= '0; bReg <= '0; modeReg <= 1'b0; emptyA <= 1'b0; emptyB <= 1'b0;
      remR <= '0; divD <= '0; qBits <= '0; cnt <= '0; baseExp <= '0;
      resSign <= 1'b0; partial <= 1'b0; denIn <= 1'b0;
      remainderOut <= '0; condCode <= '0; excFlags <= '0;
    end else begin
      if (ctl.load) begin
        aReg    <= dividendIn;
        bReg    <= modulusIn;
        modeReg <= remMode;
        emptyA  <= dividendEmpty;
        emptyB  <= modulusEmpty;
      end
      if (ctl.setup) begin
        if (invalid) begin
          remainderOut <= INDEF;
          condCode     <= '0;
          excFlags     <= {1'b1, anyEmpty, !anyEmpty && (aDen || bDen), 1'b0};
        end else if (passA) begin
          remainderOut <= aReg;
          condCode     <= '0;
          excFlags     <= {2'b00, aDen || bDen, 1'b0};
        end else begin
          divD    <= {1'b0, mB, 1'b0};
          qBits   <= '0;
          resSign <= sA;
          denIn   <= aDen || bDen;
          if (diff == MINUS1) begin
            remR    <= {2'b00, mA};
            cnt     <= '0;
            baseExp <= eBx;
            partial <= 1'b0;
          end else if (diff > MAXR_S) begin
            remR    <= {1'b0, mA, 1'b0};
            cnt     <= CNT_W'(MAX_RED + 1);
            baseExp <= eAx - MAXR_S;
            partial <= 1'b1;
          end else begin
            remR    <= {1'b0, mA, 1'b0};
            cnt     <= CNT_W'(diff + ONE_S);
            baseExp <= eBx;
            partial <= 1'b0;
          end
        end
      end
      if (ctl.step) begin
        qBits <= {qBits[1:0], geStep};
        cnt   <= cnt - CNT_W'(1);
        remR  <= stat.lastStep ? subStep : (subStep << 1);
      end
      if (ctl.round && roundUp) begin
        remR    <= divD - remR;
        resSign <= !resSign;
        qBits   <= qBits + 3'd1;
      end
      if (ctl.finish) begin
        remainderOut <= finRes;
        excFlags     <= {2'b00, finDen, finUfl};
        if (partial) condCode <= 4'b0100;
        else         condCode <= {qBits[1], 1'b0, qBits[0], qBits[2]};
      end
    end
  end

endmodule

// File: rtl/fprem_unit.sv
`timescale 1ns/1ps
module fprem_unit
  import fprem_pkg::*;
#(
  parameter int SIG_W   = 64,
  parameter int EXP_W   = 15,
  parameter int MAX_RED = 63
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic                 remMode,
  input  logic [EXP_W+SIG_W:0] dividendIn,
  input  logic [EXP_W+SIG_W:0] modulusIn,
  input  logic                 dividendEmpty,
  input  logic                 modulusEmpty,
  output logic                 done,
  output logic [EXP_W+SIG_W:0] remainderOut,
  output logic [3:0]           condCode,
  output logic                 excInvalid,
  output logic                 excStackFault,
  output logic                 excDenormal,
  output logic                 excUnderflow
);

  dpCtl_t     ctl;
  dpStat_t    stat;
  logic [3:0] excFlags;

  fprem_ctrl u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .start(start),
    .stat (stat),
    .ctl  (ctl),
    .done (done)
  );

  fprem_dp #(.SIG_W(SIG_W), .EXP_W(EXP_W), .MAX_RED(MAX_RED)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .stat         (stat),
    .remMode      (remMode),
    .dividendIn   (dividendIn),
    .modulusIn    (modulusIn),
    .dividendEmpty(dividendEmpty),
    .modulusEmpty (modulusEmpty),
    .remainderOut (remainderOut),
    .condCode     (condCode),
    .excFlags     (excFlags)
  );

  assign excInvalid    = excFlags[3];
  assign excStackFault = excFlags[2];
  assign excDenormal   = excFlags[1];
  assign excUnderflow  = excFlags[0];

endmodule

// File: rtl/fprem_unit_chk.sv
`timescale 1ns/1ps
module fprem_unit_chk #(
  parameter int SIG_W   = 64,
  parameter int EXP_W   = 15,
  parameter int MAX_RED = 63
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 start,
  input logic                 done,
  input logic [EXP_W+SIG_W:0] remainderOut,
  input logic [3:0]           condCode,
  input logic                 excInvalid,
  input logic                 excStackFault,
  input logic                 excDenormal,
  input logic                 excUnderflow
);

  localparam int FP_W  = 1 + EXP_W + SIG_W;
  localparam int LIMIT = MAX_RED + 6;
  localparam int LCW   = $clog2(LIMIT + 2);
  localparam logic [FP_W-1:0] INDEF = {1'b1, {EXP_W{1'b1}}, 2'b11, {(SIG_W-2){1'b0}}};

  logic           busy;
  logic [LCW-1:0] waitCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      waitCnt <= '0;
    end else if (done) begin
      busy    <= 1'b0;
      waitCnt <= '0;
    end else if (start && !busy) begin
      busy    <= 1'b1;
      waitCnt <= LCW'(1);
    end else if (busy && waitCnt <= LCW'(LIMIT)) begin
      waitCnt <= waitCnt + LCW'(1);
    end
  end

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_done_answers_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);
  p_latency_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (waitCnt <= LCW'(LIMIT)));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(remainderOut) && $stable(condCode)));
  p_indef_r5: assert property (@(posedge clk) disable iff (!rstN)
    (done && excInvalid) |-> (remainderOut == INDEF && condCode == 4'b0000));
  p_stack_r6: assert property (@(posedge clk) disable iff (!rstN)
    excStackFault |-> excInvalid);
  p_partial_r4: assert property (@(posedge clk) disable iff (!rstN)
    (done && condCode[2]) |-> (condCode == 4'b0100));
  p_norm_r9: assert property (@(posedge clk) disable iff (!rstN)
    (done && !excInvalid && remainderOut[FP_W-2:SIG_W] != '0) |-> remainderOut[SIG_W-1]);
  p_underflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    (done && excUnderflow) |-> (remainderOut[FP_W-2:SIG_W] == '0 && excDenormal));

endmodule

bind fprem_unit fprem_unit_chk #(.SIG_W(SIG_W), .EXP_W(EXP_W), .MAX_RED(MAX_RED)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .start        (start),
  .done         (done),
  .remainderOut (remainderOut),
  .condCode     (condCode),
  .excInvalid   (excInvalid),
  .excStackFault(excStackFault),
  .excDenormal  (excDenormal),
  .excUnderflow (excUnderflow)
);

// File: tb/test_fprem_unit.sv
`timescale 1ns/1ps
module test_fprem_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        remMode = 1'b0;
  logic [79:0] dividendIn = '0;
  logic [79:0] modulusIn = '0;
  logic        dividendEmpty = 1'b0;
  logic        modulusEmpty = 1'b0;
  logic        done;
  logic [79:0] remainderOut;
  logic [3:0]  condCode;
  logic        excInvalid, excStackFault, excDenormal, excUnderflow;

  always #4 clk = ~clk;

  fprem_unit i_fprem_unit (
    .clk(clk), .rstN(rstN), .start(start), .remMode(remMode),
    .dividendIn(dividendIn), .modulusIn(modulusIn),
    .dividendEmpty(dividendEmpty), .modulusEmpty(modulusEmpty),
    .done(done), .remainderOut(remainderOut), .condCode(condCode),
    .excInvalid(excInvalid), .excStackFault(excStackFault),
    .excDenormal(excDenormal), .excUnderflow(excUnderflow)
  );

  typedef struct {
    logic [79:0] rem;
    logic [3:0]  cc;
    logic [3:0]  fl;   // {invalid, stack, denormal, underflow}
    string       tag;
  } expItem_t;

  expItem_t sbQ[$];
  int checks = 0;
  int fails = 0;
  int issued = 0;
  int completions = 0;
  int cycles = 0;
  logic prevDone = 1'b0;
  logic [79:0] lastRem = '0;

  localparam logic [79:0] INDEF = 80'hFFFF_C000_0000_0000_0000;
  localparam logic [63:0] ONE_SIG = 64'h8000_0000_0000_0000;

  function automatic logic [79:0] fp(input logic s, input int e, input logic [63:0] m);
    logic [14:0] be;
    be = 15'(16383 + e);
    return {s, be, m};
  endfunction

  task automatic check(input bit ok, input string what, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  // monitor: pops expected items as results appear
  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      if (done && prevDone) check(1'b0, "R10 done wider than one cycle", 80'(done), 80'(0));
      if (done) begin
        if (sbQ.size() == 0) begin
          check(1'b0, "R11 unexpected done", remainderOut, 80'(0));
        end else begin
          expItem_t it;
          it = sbQ.pop_front();
          check(remainderOut == it.rem, {it.tag, " remainder"}, remainderOut, it.rem);
          check(condCode == it.cc, {it.tag, " condCode"}, 80'(condCode), 80'(it.cc));
          check({excInvalid, excStackFault, excDenormal, excUnderflow} == it.fl,
                {it.tag, " flags"},
                80'({excInvalid, excStackFault, excDenormal, excUnderflow}), 80'(it.fl));
          lastRem = remainderOut;
        end
        completions++;
      end
      prevDone = done;
    end
  end

  task automatic drive(input logic [79:0] a, input logic [79:0] b, input logic m,
                       input logic ea, input logic eb);
    @(negedge clk);
    dividendIn = a; modulusIn = b; remMode = m;
    dividendEmpty = ea; modulusEmpty = eb;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic runOp(input logic [79:0] a, input logic [79:0] b, input logic m,
                       input logic ea, input logic eb,
                       input logic [79:0] xr, input logic [3:0] xc, input logic [3:0] xf,
                       input string tag);
    expItem_t it;
    it.rem = xr; it.cc = xc; it.fl = xf; it.tag = tag;
    sbQ.push_back(it);
    issued++;
    drive(a, b, m, ea, eb);
    while (completions < issued) @(negedge clk);
    repeat (3) @(negedge clk);
    check(remainderOut == lastRem, {"R10 hold after ", tag}, remainderOut, lastRem);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(done == 1'b0 && remainderOut == '0 && condCode == '0 &&
          {excInvalid, excStackFault, excDenormal, excUnderflow} == '0,
          "R10 reset state", remainderOut, 80'(0));

    // R1 truncating
    runOp(fp(0,3,64'hB000_0000_0000_0000), fp(0,2,64'hE000_0000_0000_0000), 0, 0, 0,
          fp(0,2,ONE_SIG), 4'b0010, 4'b0000, "R1 11 rem 7 trunc");
    runOp(fp(1,3,64'hB000_0000_0000_0000), fp(0,2,64'hE000_0000_0000_0000), 0, 0, 0,
          fp(1,2,ONE_SIG), 4'b0010, 4'b0000, "R1 -11 rem 7 trunc");
    // R3 quotient 14: C0=Q2=1, C1=Q0=0, C3=Q1=1
    runOp(fp(0,6,64'hC800_0000_0000_0000), fp(0,2,64'hE000_0000_0000_0000), 0, 0, 0,
          fp(0,1,ONE_SIG), 4'b1001, 4'b0000, "R3 100 rem 7");
    // R2 nearest
    runOp(fp(0,3,64'hB000_0000_0000_0000), fp(0,2,64'hE000_0000_0000_0000), 1, 0, 0,
          fp(1,1,64'hC000_0000_0000_0000), 4'b1000, 4'b0000, "R2 11 rem 7 nearest");
    runOp(fp(0,3,64'hA000_0000_0000_0000), fp(0,2,64'hE000_0000_0000_0000), 1, 0, 0,
          fp(0,1,64'hC000_0000_0000_0000), 4'b0010, 4'b0000, "R2 10 rem 7 nearest");
    runOp(fp(0,3,64'hA800_0000_0000_0000), fp(0,2,64'hE000_0000_0000_0000), 1, 0, 0,
          fp(1,1,64'hE000_0000_0000_0000), 4'b1000, 4'b0000, "R2 tie odd 10.5 rem 7");
    runOp(fp(0,1,64'hE000_0000_0000_0000), fp(0,2,64'hE000_0000_0000_0000), 1, 0, 0,
          fp(0,1,64'hE000_0000_0000_0000), 4'b0000, 4'b0000, "R2 tie even 3.5 rem 7");
    runOp(fp(0,1,64'hF000_0000_0000_0000), fp(0,2,64'hE000_0000_0000_0000), 1, 0, 0,
          fp(1,1,64'hD000_0000_0000_0000), 4'b0010, 4'b0000, "R2 3.75 rem 7 nearest");
    runOp(fp(0,1,64'hF000_0000_0000_0000), fp(0,2,64'hE000_0000_0000_0000), 0, 0, 0,
          fp(0,1,64'hF000_0000_0000_0000), 4'b0000, 4'b0000, "R9 3.75 rem 7 trunc unchanged");
    // R9 zero results and pass-through
    runOp(fp(1,3,64'hE000_0000_0000_0000), fp(0,2,64'hE000_0000_0000_0000), 0, 0, 0,
          {1'b1, 79'd0}, 4'b1000, 4'b0000, "R9 -14 rem 7 signed zero");
    runOp(80'd0, fp(0,2,64'hE000_0000_0000_0000), 1, 0, 0,
          80'd0, 4'b0000, 4'b0000, "R9 zero dividend");
    runOp(fp(0,2,64'hA000_0000_0000_0000), {1'b0, 15'h7FFF, ONE_SIG}, 0, 0, 0,
          fp(0,2,64'hA000_0000_0000_0000), 4'b0000, 4'b0000, "R9 infinite modulus");
    // R3 and R4: exact 63 limit vs partial
    runOp(fp(0,64,ONE_SIG), fp(0,1,64'hC000_0000_0000_0000), 0, 0, 0,
          fp(0,0,ONE_SIG), 4'b0011, 4'b0000, "R3 2^64 rem 3 full");
    runOp(fp(0,100,ONE_SIG), fp(0,1,64'hC000_0000_0000_0000), 0, 0, 0,
          fp(0,36,ONE_SIG), 4'b0100, 4'b0000, "R4 2^100 rem 3 partial");
    // R5 / R6 invalid cases
    runOp(fp(0,3,ONE_SIG), fp(0,2,ONE_SIG), 0, 1, 0,
          INDEF, 4'b0000, 4'b1100, "R6 empty dividend");
    runOp(fp(0,3,ONE_SIG), fp(0,2,ONE_SIG), 0, 0, 1,
          INDEF, 4'b0000, 4'b1100, "R6 empty modulus");
    runOp(fp(0,3,ONE_SIG), 80'd0, 0, 0, 0,
          INDEF, 4'b0000, 4'b1000, "R5 zero modulus");
    runOp({1'b0, 15'h7FFF, ONE_SIG}, fp(0,2,ONE_SIG), 1, 0, 0,
          INDEF, 4'b0000, 4'b1000, "R5 infinite dividend");
    runOp(fp(0,3,ONE_SIG), {1'b0, 15'h7FFF, 64'hC000_0000_0000_0000}, 0, 0, 0,
          INDEF, 4'b0000, 4'b1000, "R5 NaN modulus");
    // R7 denormal operand
    runOp({1'b0, 15'd0, 64'd1}, fp(0,2,64'hE000_0000_0000_0000), 0, 0, 0,
          {1'b0, 15'd0, 64'd1}, 4'b0000, 4'b0010, "R7 denormal dividend");
    // R8 underflow
    runOp({1'b0, 15'd2, ONE_SIG}, {1'b0, 15'd1, 64'hC000_0000_0000_0000}, 0, 0, 0,
          {1'b0, 15'd0, 64'h4000_0000_0000_0000}, 4'b0010, 4'b0011, "R8 underflow");

    // R11: second start during a long run and changed operands are ignored
    begin
      expItem_t it;
      it.rem = fp(0,0,ONE_SIG); it.cc = 4'b0011; it.fl = 4'b0000;
      it.tag = "R11 start while busy";
      sbQ.push_back(it);
      issued++;
      drive(fp(0,64,ONE_SIG), fp(0,1,64'hC000_0000_0000_0000), 0, 0, 0);
      repeat (3) @(negedge clk);
      drive(fp(0,3,ONE_SIG), 80'd0, 1, 1, 1);
      while (completions < issued) @(negedge clk);
      repeat (80) @(negedge clk);
      check(completions == issued, "R11 single done", 80'(completions), 80'(issued));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule